// File: doc/BRIEF.md
# Vectored Three-Source Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It has three sources: a USB event line and two timer overflow lines. A single 8-bit control register holds a master enable, one enable per source, and one pending flag per source. Each source pulse latches its flag. The block then works out whether the core should take a vectored call. It presents the call and its target address until the core acknowledges it.

On acknowledgement the block clears the serviced flag and the master enable, so routines do not nest unless firmware allows it. A return strobe that re-enables restores the master enable. A plain return leaves it cleared. While the core reports a full return stack, no call is offered, and pending requests wait until room is available.

Top module: `intc_vec3`

## Requirements
- R1: After reset the register reads 0x00. A write stores bits 6:0. Bit 0 is the master enable, bits 1/2/3 are the USB/timer-0/timer-1 enables, and bits 4/5/6 are the USB/timer-0/timer-1 pending flags. Bit 7 always reads 0. All bits are active-high.
- R2: A source pulse sets its pending flag on the next clock edge, even while the master enable is 0.
- R3: `call_req` is 1 only when the master enable is 1 and, for some source, both its enable and its flag are 1.
- R4: `call_vec` is 0x04 for USB, 0x08 for timer-0 and 0x0C for timer-1, and 0x00 while `call_req` is 0.
- R5: While `stk_full` is 1, `call_req` is 0 and an acknowledge has no effect. The pending flag stays set and is offered once `stk_full` returns to 0.
- R6: An acknowledge while `call_req` is 1 clears the master enable and the flag of the offered source. The other flags are left unchanged.
- R7: `ret_en` sets the master enable to 1. `ret_plain` changes no register bit.
- R8: When several sources are eligible, USB is offered first, then timer-0, then timer-1.
- R9: A source pulse in the same cycle as a write, or as an acknowledge, that would clear its flag leaves the flag at 1.
- R10: If firmware writes the master enable back to 1 while a flag is pending and enabled, the call is offered again.
- R11: `call_req` and `call_vec` hold steady until an acknowledge or a register change removes eligibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| usb_evt | input | 1 | USB event pulse |
| tmr0_ovf | input | 1 | Timer-0 overflow pulse |
| tmr1_ovf | input | 1 | Timer-1 overflow pulse |
| stk_full | input | 1 | Return stack is full |
| call_ack | input | 1 | Core accepts the offered call |
| ret_en | input | 1 | Return that re-enables interrupts |
| ret_plain | input | 1 | Return that leaves enables unchanged |
| call_req | output | 1 | Vectored call offered to the core |
| call_vec | output | 8 | Target address of the offered call |

## Verification
The bench targets the collision cases:
- A source pulse that coincides with a clearing write. A design that lets the write win loses the event.
- A pulse that coincides with an acknowledge of the same source. A design that lets the acknowledge win drops the second occurrence.

It also holds `stk_full` high while an acknowledge is driven. A design that honours the acknowledge anyway clears a flag for a call the core never took.

The bench checks that a plain return leaves the master enable at 0, and that a firmware write restoring it re-offers a pending call. Each of these would fail on a design that treats the two returns alike, or that cannot nest.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC     = 3;
    localparam int DW       = 8;
    localparam int VEC_BASE = 4;
    localparam int VEC_STEP = 4;

    // packing order gives gie at bit 0, enables at 3:1, flags at 6:4
    typedef struct packed {
        logic [NSRC-1:0] flg;
        logic [NSRC-1:0] en;
        logic            gie;
    } ctl_t;

    localparam int CTLW = $bits(ctl_t);

    function automatic logic [DW-1:0] vec_of(input int idx);
        return DW'(VEC_BASE + idx * VEC_STEP);
    endfunction
endpackage

// File: rtl/intc_ctl_reg.sv
module intc_ctl_reg
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] evt,
    input  logic            take,
    input  logic [NSRC-1:0] take_sel,
    input  logic            ret_en,
    output ctl_t            q
);
    ctl_t nxt;

    always_comb begin
        nxt = q;
        if (wr)
            nxt = ctl_t'(wdata[CTLW-1:0]);
        if (ret_en)
            nxt.gie = 1'b1;
        if (take) begin
            nxt.gie = 1'b0;
            nxt.flg = nxt.flg & ~take_sel;
        end
        nxt.flg = nxt.flg | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((q.flg & $past(evt)) == $past(evt)));   // R9

    AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
        (take && !ret_en) |=> !q.gie);                       // R6

    AST_RETEN_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
        (ret_en && !take) |=> q.gie);                        // R7
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctl_t            ctl,
    input  logic            stk_full,
    output logic [NSRC-1:0] grant,
    output logic            req,
    output logic [DW-1:0]  vec
);
    logic [NSRC-1:0] elig;
    logic [NSRC:0]   seen;

    assign elig    = ctl.flg & ctl.en & {NSRC{ctl.gie & ~stk_full}};
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_prio
        assign grant[i]  = elig[i] & ~seen[i];
        assign seen[i+1] = seen[i] | elig[i];
    end

    assign req = seen[NSRC];

    always_comb begin
        vec = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant[i]) vec = vec_of(i);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));                                    // R8

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        stk_full |-> !req);                                  // R5

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        req |-> ctl.gie);                                    // R3
endmodule

// File: rtl/intc_vec3.sv
module intc_vec3
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          usb_evt,
    input  logic          tmr0_ovf,
    input  logic          tmr1_ovf,
    input  logic          stk_full,
    input  logic          call_ack,
    input  logic          ret_en,
    input  logic          ret_plain,
    output logic          call_req,
    output logic [DW-1:0] call_vec
);
    ctl_t            ctl;
    logic [NSRC-1:0] grant;
    logic            take;

    assign take = call_ack & call_req;

    intc_ctl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .evt      ({tmr1_ovf, tmr0_ovf, usb_evt}),
        .take     (take),
        .take_sel (grant),
        .ret_en   (ret_en),
        .q        (ctl)
    );

    intc_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .stk_full (stk_full),
        .grant    (grant),
        .req      (call_req),
        .vec      (call_vec)
    );

    assign reg_rdata = {{(DW-CTLW){1'b0}}, ctl};

    AST_PLAIN_RET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ret_plain && !ret_en && !reg_wr && !call_ack
         && !usb_evt && !tmr0_ovf && !tmr1_ovf)
        |=> (reg_rdata == $past(reg_rdata)));                // R7

    AST_FULL_NO_CHANGE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (stk_full && call_ack && !reg_wr && !ret_en
         && !usb_evt && !tmr0_ovf && !tmr1_ovf)
        |=> (reg_rdata == $past(reg_rdata)));                // R5
endmodule

// File: tb/intc_vec3_tb.sv
module intc_vec3_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       wr;
        logic [7:0] wdata;
        logic [2:0] evt;      // {tmr1, tmr0, usb}
        logic       stkf;
        logic       ack;
        logic       reti;
        logic       rplain;
        logic [7:0] exp_rd;
        logic       exp_req;
        logic [7:0] exp_vec;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1, 8'h0F, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, 8'h00}, // R1 write enables
        '{1'b0, 8'h00, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b1, 8'h04}, // R2 R3 R4 usb
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0E, 1'b0, 8'h00}, // R6 entry
        '{1'b0, 8'h00, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6E, 1'b0, 8'h00}, // R2 latched while gie 0
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h6F, 1'b1, 8'h08}, // R7 R8 timer0 first
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h6F, 1'b0, 8'h00}, // R5 stack full
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h6F, 1'b0, 8'h00}, // R5 ack ignored
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h4E, 1'b0, 8'h00}, // R5 R6 taken after room
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h4E, 1'b0, 8'h00}, // R7 plain return
        '{1'b1, 8'h4F, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h4F, 1'b1, 8'h0C}, // R10 nesting
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h4F, 1'b1, 8'h0C}, // R11 held
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0E, 1'b0, 8'h00}, // R6 timer1 taken
        '{1'b1, 8'h00, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 8'h00}, // R9 event beats write
        '{1'b1, 8'hFF, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b1, 8'h04}, // R1 R8 bit7 zero, usb first
        '{1'b0, 8'h00, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0, 8'h00}  // R9 event beats ack
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       usb_evt = 1'b0, tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic       stk_full = 1'b0, call_ack = 1'b0, ret_en = 1'b0, ret_plain = 1'b0;
    logic       call_req;
    logic [7:0] call_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    intc_vec3 u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .usb_evt(usb_evt), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .stk_full(stk_full), .call_ack(call_ack),
        .ret_en(ret_en), .ret_plain(ret_plain),
        .call_req(call_req), .call_vec(call_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input step_t s);
        @(negedge clk);
        reg_wr    = s.wr;
        reg_wdata = s.wdata;
        {tmr1_ovf, tmr0_ovf, usb_evt} = s.evt;
        stk_full  = s.stkf;
        call_ack  = s.ack;
        ret_en    = s.reti;
        ret_plain = s.rplain;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R3 reset req", {7'b0, call_req}, 8'h00);

        for (int i = 0; i < NSTEP; i++) begin
            drive(TBL[i]);
            check($sformatf("step%0d rdata R1", i), reg_rdata, TBL[i].exp_rd);
            check($sformatf("step%0d req R3", i), {7'b0, call_req}, {7'b0, TBL[i].exp_req});
            check($sformatf("step%0d vec R4", i), call_vec, TBL[i].exp_vec);
        end

        // R1: writing only bit 7 leaves everything clear
        drive('{1'b1, 8'h80, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00});
        check("R1 bit7 write", reg_rdata, 8'h00);

        // R5: pending request waits through full stack and is offered when it clears
        drive('{1'b1, 8'h09, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00});
        check("R5 full holds", {7'b0, call_req}, 8'h00);
        check("R5 flag kept", reg_rdata, 8'h49);
        drive('{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00});
        check("R5 offered later", call_vec, 8'h0C);

        // R1: reset mid-run clears state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid reset", reg_rdata, 8'h00);
        check("R3 mid reset req", {7'b0, call_req}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule